// File: doc/BRIEF.md
# Clock Source Switch Controller

This block decides which of two oscillators drives the system clock: an internal RC-style oscillator or a primary crystal oscillator, optionally followed by a PLL. Software writes a two-bit source select. When it asks for the primary source while the system runs from the internal one, the system stays on the internal clock. Meanwhile a start-up timer in the primary domain counts primary periods and, when the PLL is on, a further lock interval. Only then does a two-sided handshake move the system clock over.

The controller drives one enable per clock domain for a downstream gating mux. Each enable is resynchronised through two flops in its own domain and changes on that clock's falling edge. The new clock's enable rises only after the old clock's enable has been seen low. Two status flags report the internal oscillator as stable and the primary start-up as complete. An oscillator-enable output keeps the internal oscillator alive on the primary source when the watchdog or the clock monitor needs it. A busy output marks an unfinished request. The controller logic runs in the internal-oscillator domain.

Top module: `css_top`

## Requirements
- R1: After synchronous reset, clk_sel is 0 (internal source), en_int is 1, en_pri is 0, and int_stable, pri_ready and busy are 0.
- R2: int_stable rises only after the internal oscillator has been enabled for INT_STAB controller cycles, and rises within a few cycles after that.
- R3: src_sel = 2'b00 selects the primary source and any other value selects the internal one. With pll_en = 0, clk_sel stays 0 until at least OST_CYC primary-clock periods have passed since the request, and it rises within 40 primary periods after that.
- R4: With pll_en = 1, the wait before clk_sel rises is at least OST_CYC + PLL_CYC primary periods and at most 40 periods more.
- R5: In the cycle clk_sel rises, int_stable is 0 and pri_ready is 1. When clk_sel returns to 0, pri_ready is 0.
- R6: While settled on the primary source, int_osc_en equals wdt_en OR fscm_en. On the internal source it is 1.
- R7: If the internal oscillator is still settled, a switch back to it completes in at most 25 controller cycles, and int_stable never drops during an abandoned primary request. If the oscillator had been off, the switch back takes at least INT_STAB cycles.
- R8: en_int and en_pri are never high together.
- R9: A select change back to internal during the start-up wait abandons the wait. A later primary request counts a full OST_CYC periods again.
- R10: busy is high from a select change until clk_sel has settled on the requested source. It is 0 when the two agree and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock; also the controller clock |
| clk_pri | input | 1 | Primary oscillator (and PLL) clock |
| rst | input | 1 | Synchronous active-high reset, clk_int domain |
| src_sel | input | 2 | Source select: 2'b00 primary, other values internal |
| pll_en | input | 1 | Adds the PLL lock interval after start-up |
| wdt_en | input | 1 | Watchdog enabled; keeps internal oscillator alive |
| fscm_en | input | 1 | Clock monitor enabled; keeps internal oscillator alive |
| clk_sel | output | 1 | Settled system clock source, 1 = primary |
| en_int | output | 1 | Gate enable for the internal clock at the mux |
| en_pri | output | 1 | Gate enable for the primary clock at the mux |
| int_stable | output | 1 | Internal oscillator stable flag |
| pri_ready | output | 1 | Primary start-up complete flag |
| int_osc_en | output | 1 | Internal oscillator enable |
| busy | output | 1 | Request not yet settled |

## Verification
The hardest state to reach is a start-up count abandoned part-way and then restarted. Only a restarted count shows whether the primary-domain counter was really cleared, since a leftover count would end the second wait early. The stimulus requests the primary source, withdraws the request after about 430 primary periods and then requests it again. It measures the second wait in primary periods against the full start-up count. A sweep over every combination of PLL, watchdog and monitor enables runs a complete round trip. It shows both switch-back latencies, with the internal oscillator kept alive and with it stopped.

// File: rtl/css_pkg.sv
package css_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_PRI,
    ST_WAIT_INT,
    ST_OFF,
    ST_ON
  } css_state_t;
endpackage

// File: rtl/css_sync2.sv
module css_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [1:0] s;

  always_ff @(posedge clk) begin
    if (rst) s <= {2{RST_VAL}};
    else     s <= {s[0], d};
  end

  assign q = s[1];
endmodule

// File: rtl/css_gate.sv
module css_gate #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic want,
  output logic en
);
  logic want_s;

  css_sync2 #(.RST_VAL(RST_VAL)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (want),
    .q   (want_s)
  );

  // change only while this clock is low
  always_ff @(negedge clk) begin
    if (rst) en <= RST_VAL;
    else     en <= want_s;
  end
endmodule

// File: rtl/css_pri_timer.sv
module css_pri_timer #(
  parameter int unsigned OST_CYC = 1024,
  parameter int unsigned PLL_CYC = 80000
) (
  input  logic clk_pri,
  input  logic rst_p,
  input  logic start,
  input  logic pll_en,
  output logic run,
  output logic ready
);
  localparam int unsigned TOTAL = OST_CYC + PLL_CYC;
  localparam int unsigned CW    = $clog2(TOTAL + 1);

  logic          start_s;
  logic          pll_s;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  css_sync2 u_start (.clk(clk_pri), .rst(rst_p), .d(start),  .q(start_s));
  css_sync2 u_pll   (.clk(clk_pri), .rst(rst_p), .d(pll_en), .q(pll_s));

  assign lim = pll_s ? CW'(TOTAL - 1) : CW'(OST_CYC - 1);

  always_ff @(posedge clk_pri) begin
    if (rst_p) begin
      cnt   <= '0;
      ready <= 1'b0;
      run   <= 1'b0;
    end else begin
      run <= start_s;
      if (!start_s) begin
        cnt   <= '0;
        ready <= 1'b0;
      end else if (!ready) begin
        cnt <= cnt + 1'b1;
        if (cnt == lim) ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/css_ctrl.sv
module css_ctrl
  import css_pkg::*;
#(
  parameter int unsigned INT_STAB = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src_sel,
  input  logic       wdt_en,
  input  logic       fscm_en,
  input  logic       tmr_rdy_s,
  input  logic       tmr_run_s,
  input  logic       en_int_s,
  input  logic       en_pri_s,
  output logic       tmr_start,
  output logic       want_int,
  output logic       want_pri,
  output logic       sel_pri,
  output logic       int_stable,
  output logic       pri_ready,
  output logic       int_osc_en,
  output logic       busy
);
  localparam int unsigned SW = $clog2(INT_STAB + 1);

  css_state_t    st;
  logic          tgt_pri;
  logic          int_settled;
  logic [SW-1:0] stab_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      tgt_pri     <= 1'b0;
      sel_pri     <= 1'b0;
      want_int    <= 1'b1;
      want_pri    <= 1'b0;
      tmr_start   <= 1'b0;
      int_settled <= 1'b0;
      stab_cnt    <= '0;
      int_stable  <= 1'b0;
      pri_ready   <= 1'b0;
      int_osc_en  <= 1'b1;
    end else begin
      tgt_pri <= (src_sel == 2'b00);

      if (!int_osc_en)                  stab_cnt <= '0;
      else if (stab_cnt != SW'(INT_STAB)) stab_cnt <= stab_cnt + 1'b1;
      int_settled <= int_osc_en && (stab_cnt == SW'(INT_STAB));

      if (!sel_pri && int_settled) int_stable <= 1'b1;

      case (st)
        ST_IDLE: begin
          if (tgt_pri && !sel_pri) begin
            if (!tmr_rdy_s && !tmr_run_s) begin
              tmr_start <= 1'b1;
              st        <= ST_WAIT_PRI;
            end
          end else if (!tgt_pri && sel_pri) begin
            int_osc_en <= 1'b1;
            st         <= ST_WAIT_INT;
          end else if (sel_pri) begin
            int_osc_en <= wdt_en | fscm_en;
          end
        end
        ST_WAIT_PRI: begin
          if (!tgt_pri) begin
            tmr_start <= 1'b0;
            st        <= ST_IDLE;
          end else if (tmr_rdy_s) begin
            want_int <= 1'b0;
            st       <= ST_OFF;
          end
        end
        ST_WAIT_INT: begin
          if (tgt_pri) begin
            st <= ST_IDLE;
          end else if (int_settled) begin
            int_stable <= 1'b1;
            want_pri   <= 1'b0;
            st         <= ST_OFF;
          end
        end
        ST_OFF: begin
          if (!sel_pri && !en_int_s) begin
            want_pri <= 1'b1;
            st       <= ST_ON;
          end else if (sel_pri && !en_pri_s) begin
            want_int <= 1'b1;
            st       <= ST_ON;
          end
        end
        ST_ON: begin
          if (!sel_pri && en_pri_s) begin
            sel_pri    <= 1'b1;
            int_stable <= 1'b0;
            pri_ready  <= 1'b1;
            int_osc_en <= wdt_en | fscm_en;
            st         <= ST_IDLE;
          end else if (sel_pri && en_int_s) begin
            sel_pri   <= 1'b0;
            pri_ready <= 1'b0;
            tmr_start <= 1'b0;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE) || (tgt_pri != sel_pri);
endmodule

// File: rtl/css_top.sv
module css_top #(
  parameter int unsigned OST_CYC  = 1024,
  parameter int unsigned PLL_CYC  = 80000,
  parameter int unsigned INT_STAB = 64
) (
  input  logic       clk_int,
  input  logic       clk_pri,
  input  logic       rst,
  input  logic [1:0] src_sel,
  input  logic       pll_en,
  input  logic       wdt_en,
  input  logic       fscm_en,
  output logic       clk_sel,
  output logic       en_int,
  output logic       en_pri,
  output logic       int_stable,
  output logic       pri_ready,
  output logic       int_osc_en,
  output logic       busy
);
  localparam int unsigned NDOM = 2;

  logic            rst_p;
  logic            tmr_start, tmr_run, tmr_rdy, tmr_run_s, tmr_rdy_s;
  logic            want_int, want_pri;
  logic            en_int_s, en_pri_s;
  logic [NDOM-1:0] dom_clk, dom_rst, dom_want, dom_en;

  css_sync2 #(.RST_VAL(1'b1)) u_rst_p (
    .clk(clk_pri), .rst(1'b0), .d(rst), .q(rst_p)
  );

  css_pri_timer #(.OST_CYC(OST_CYC), .PLL_CYC(PLL_CYC)) u_timer (
    .clk_pri (clk_pri),
    .rst_p   (rst_p),
    .start   (tmr_start),
    .pll_en  (pll_en),
    .run     (tmr_run),
    .ready   (tmr_rdy)
  );

  css_sync2 u_rdy_s (.clk(clk_int), .rst(rst), .d(tmr_rdy), .q(tmr_rdy_s));
  css_sync2 u_run_s (.clk(clk_int), .rst(rst), .d(tmr_run), .q(tmr_run_s));

  // index 0: internal domain, index 1: primary domain
  assign dom_clk  = {clk_pri, clk_int};
  assign dom_rst  = {rst_p, rst};
  assign dom_want = {want_pri, want_int};

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    css_gate #(.RST_VAL((g == 0) ? 1'b1 : 1'b0)) u_gate (
      .clk  (dom_clk[g]),
      .rst  (dom_rst[g]),
      .want (dom_want[g]),
      .en   (dom_en[g])
    );
  end

  assign en_int = dom_en[0];
  assign en_pri = dom_en[1];

  css_sync2 #(.RST_VAL(1'b1)) u_eni_s (.clk(clk_int), .rst(rst), .d(en_int), .q(en_int_s));
  css_sync2                   u_enp_s (.clk(clk_int), .rst(rst), .d(en_pri), .q(en_pri_s));

  css_ctrl #(.INT_STAB(INT_STAB)) u_ctrl (
    .clk        (clk_int),
    .rst        (rst),
    .src_sel    (src_sel),
    .wdt_en     (wdt_en),
    .fscm_en    (fscm_en),
    .tmr_rdy_s  (tmr_rdy_s),
    .tmr_run_s  (tmr_run_s),
    .en_int_s   (en_int_s),
    .en_pri_s   (en_pri_s),
    .tmr_start  (tmr_start),
    .want_int   (want_int),
    .want_pri   (want_pri),
    .sel_pri    (clk_sel),
    .int_stable (int_stable),
    .pri_ready  (pri_ready),
    .int_osc_en (int_osc_en),
    .busy       (busy)
  );
endmodule

// File: rtl/css_chk.sv
module css_chk (
  input logic clk_int,
  input logic rst,
  input logic clk_sel,
  input logic en_int,
  input logic en_pri,
  input logic int_stable,
  input logic pri_ready,
  input logic int_osc_en,
  input logic busy,
  input logic wdt_en,
  input logic fscm_en,
  input logic tmr_rdy_s
);
  a_r1_reset_state: assert property (@(posedge clk_int)
    $past(rst) |-> (!clk_sel && !pri_ready && !int_stable));

  a_r8_no_overlap: assert property (@(posedge clk_int) disable iff (rst)
    !(en_int && en_pri));

  a_r3_wait_ready: assert property (@(posedge clk_int) disable iff (rst)
    $rose(clk_sel) |-> $past(tmr_rdy_s));

  a_r5_flags_up: assert property (@(posedge clk_int) disable iff (rst)
    $rose(clk_sel) |-> (pri_ready && !int_stable));

  a_r5_flags_down: assert property (@(posedge clk_int) disable iff (rst)
    $fell(clk_sel) |-> !pri_ready);

  a_r10_busy_before_move: assert property (@(posedge clk_int) disable iff (rst)
    (clk_sel != $past(clk_sel)) |-> $past(busy));

  a_r6_keep_osc: assert property (@(posedge clk_int) disable iff (rst)
    (clk_sel && !busy && $past(clk_sel) && !$past(busy))
      |-> (int_osc_en == $past(wdt_en || fscm_en)));

  a_r8_sel_matches_gate: assert property (@(posedge clk_int) disable iff (rst)
    $rose(clk_sel) |-> !en_int);
endmodule

bind css_top css_chk u_chk (
  .clk_int    (clk_int),
  .rst        (rst),
  .clk_sel    (clk_sel),
  .en_int     (en_int),
  .en_pri     (en_pri),
  .int_stable (int_stable),
  .pri_ready  (pri_ready),
  .int_osc_en (int_osc_en),
  .busy       (busy),
  .wdt_en     (wdt_en),
  .fscm_en    (fscm_en),
  .tmr_rdy_s  (tmr_rdy_s)
);

// File: tb/test_css_top.sv
module test_css_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRI_PERIOD = 7;
  localparam int OST        = 1024;
  localparam int PLL        = 64;
  localparam int STAB       = 40;
  localparam int MARGIN     = 40;

  logic       clk_int = 1'b0;
  logic       clk_pri = 1'b0;
  logic       rst     = 1'b1;
  logic [1:0] src_sel = 2'b10;
  logic       pll_en  = 1'b0;
  logic       wdt_en  = 1'b0;
  logic       fscm_en = 1'b0;
  logic       clk_sel, en_int, en_pri, int_stable, pri_ready, int_osc_en, busy;

  int checks = 0;
  int fails  = 0;
  int pri_edges = 0;
  int overlaps  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_int = ~clk_int;
  always #(PRI_PERIOD/2.0) clk_pri = ~clk_pri;
  always @(posedge clk_pri) pri_edges++;
  always @(posedge clk_int) if (!rst && en_int && en_pri) overlaps++;

  css_top #(.OST_CYC(OST), .PLL_CYC(PLL), .INT_STAB(STAB)) i_css_top (
    .clk_int(clk_int), .clk_pri(clk_pri), .rst(rst), .src_sel(src_sel),
    .pll_en(pll_en), .wdt_en(wdt_en), .fscm_en(fscm_en), .clk_sel(clk_sel),
    .en_int(en_int), .en_pri(en_pri), .int_stable(int_stable),
    .pri_ready(pri_ready), .int_osc_en(int_osc_en), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_int);
  endtask

  // request primary, return primary periods until clk_sel rises
  task automatic to_primary(output int edges);
    int e0;
    @(negedge clk_int);
    src_sel = 2'b00;
    e0 = pri_edges;
    while (!clk_sel) @(negedge clk_int);
    edges = pri_edges - e0;
  endtask

  task automatic to_internal(input logic [1:0] code, output int cyc);
    @(negedge clk_int);
    src_sel = code;
    cyc = 0;
    while (clk_sel) begin
      @(negedge clk_int);
      cyc++;
    end
  endtask

  initial begin
    int e, n, expw;
    bit keep;
    wait_cyc(4);
    rst = 1'b0;
    @(negedge clk_int);
    // R1 reset state
    chk(clk_sel == 0, "R1 clk_sel", clk_sel, 0);
    chk(en_int == 1 && en_pri == 0, "R1 enables", {en_int, en_pri}, 2);
    chk(int_stable == 0, "R1 int_stable", int_stable, 0);
    chk(pri_ready == 0, "R1 pri_ready", pri_ready, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    // R2 stabilisation window
    wait_cyc(STAB - 12);
    chk(int_stable == 0, "R2 early", int_stable, 0);
    wait_cyc(20);
    chk(int_stable == 1, "R2 settled", int_stable, 1);

    // sweep over pll, watchdog and monitor enables
    for (int c = 0; c < 8; c++) begin
      pll_en  = c[0];
      wdt_en  = c[1];
      fscm_en = c[2];
      keep    = c[1] | c[2];
      expw    = c[0] ? OST + PLL : OST;
      fork
        to_primary(e);
        begin
          wait_cyc(3);
          chk(busy == 1, "R10 busy on request", busy, 1);
        end
      join
      if (c[0]) chk(e >= expw && e <= expw + MARGIN, "R4 pll wait", e, expw);
      else      chk(e >= expw && e <= expw + MARGIN, "R3 start-up wait", e, expw);
      chk(pri_ready == 1 && int_stable == 0, "R5 flags on primary",
          {pri_ready, int_stable}, 2);
      wait_cyc(3);
      chk(int_osc_en == keep, "R6 internal osc enable", int_osc_en, keep);
      chk(busy == 0, "R10 busy settled", busy, 0);
      to_internal((c[0] ? 2'b01 : 2'b11), n);
      if (keep) chk(n <= 25, "R7 fast return", n, 25);
      else      chk(n >= STAB, "R7 restabilise", n, STAB);
      chk(pri_ready == 0, "R5 pri_ready cleared", pri_ready, 0);
      chk(int_stable == 1 && int_osc_en == 1, "R6 on internal",
          {int_stable, int_osc_en}, 3);
      wait_cyc(5);
    end

    // R9 abandoned start-up then a full restart
    pll_en = 1'b0; wdt_en = 1'b0; fscm_en = 1'b0;
    @(negedge clk_int);
    src_sel = 2'b00;
    wait_cyc(300);
    chk(clk_sel == 0, "R3 held on internal", clk_sel, 0);
    chk(int_stable == 1, "R7 stays set while waiting", int_stable, 1);
    src_sel = 2'b10;
    wait_cyc(20);
    chk(busy == 0 && clk_sel == 0, "R9 abort settles", {busy, clk_sel}, 0);
    chk(int_stable == 1, "R7 stays set after abort", int_stable, 1);
    to_primary(e);
    chk(e >= OST && e <= OST + MARGIN, "R9 full recount", e, OST);

    chk(overlaps == 0, "R8 enable overlap", overlaps, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_int);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule